// File: doc/BRIEF.md
# Timed Read Controller for an Asynchronous 16-bit One-Time-Programmable Memory

This block sits between a synchronous host and an asynchronous, word-wide one-time-programmable memory. The memory has an 18-bit address bus, a 16-bit data bus and two active-low strobes: chip enable and output enable. The host offers an address with a valid/ready handshake. The controller then drives the address and the strobes in a timed order. It captures the data word once every access limit has passed and returns the word with a single-cycle valid pulse.

The memory comes in four speed grades. The grade is chosen by a parameter, and the clock period is given in nanoseconds. At elaboration the controller turns the three access limits into whole clock cycles by rounding up. The limits are measured from the address, from chip enable and from output enable, and each has its own counter. The same rounding gives the float time. Output enable is held back until late in the access, so it is asserted for as short a time as the access allows. After a read, the controller waits out the float time before it takes the next request, so a second driver never meets data the memory is still driving. In the optional standby mode chip enable is released between reads. Otherwise chip enable stays asserted from the first cycle after reset.

Top module: `eprom_rd`

## Requirements
- R1: While reset is asserted, reqReady is 1, memCeN and memOeN are 1 and rspValid is 0.
- R2: A request is taken at a clock edge where reqValid and reqReady are both 1. After that edge memAddr equals the offered address, and it does not change until the next request is taken. In standby mode memCeN goes low at that same edge.
- R3: memOeN goes low exactly ACC_CYC minus OE_CYC cycles after the edge that takes the request. This is 15 cycles with the default parameters.
- R4: rspValid rises exactly ACC_CYC cycles after the edge that takes the request. At that point the address, chip-enable and output-enable limits have all been met. rspData carries the memData value sampled at that edge.
- R5: memOeN returns to 1 at the same edge where rspValid rises. In standby mode memCeN also returns to 1 at that edge.
- R6: reqReady stays 0 from the taking edge until DF_CYC cycles after memOeN returns to 1. While reqReady is 0, reqValid is ignored: memAddr does not change and no extra response is produced.
- R7: With STANDBY_EN=0, memCeN goes low at the first edge after reset is released and stays low.
- R8: Each limit in cycles is ceil(ns / CLK_NS). The GRADE parameter selects the limits in nanoseconds:

  | GRADE | Access | Output enable | Float |
  |-------|--------|---------------|-------|
  | 0     | 85     | 40            | 30    |
  | 1     | 100    | 40            | 30    |
  | 2     | 120    | 40            | 35    |
  | 3     | 150    | 50            | 40    |

  The chip-enable limit equals the access limit. With GRADE=1 and CLK_NS=4 the limits are 25, 10 and 8 cycles.
- R9: rspValid is high for exactly one cycle per read. rspData holds its value until the next response.
- R10: memOeN is never 0 while memCeN is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host offers a read |
| reqAddr | input | ADDR_W | Word address of the read |
| reqReady | output | 1 | Controller can take a request |
| rspValid | output | 1 | One-cycle pulse: rspData is new |
| rspData | output | DATA_W | Captured word |
| memAddr | output | ADDR_W | Address bus to the memory |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memData | input | DATA_W | Data bus from the memory |

## Verification
A counter that is off by one moves the output-enable edge, the capture edge or the return of reqReady by one cycle. A cycle-exact model compares every output on every clock, so such an error shows in the first read after reset. An early capture also returns a wrong word, because the memory model drives a junk value until all three limits are met. A state machine that takes a request while the float time is still running shows as a memAddr change or an extra response, in the same cycle as the early acceptance.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

  // control strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic launch;   // take request, drive address
    logic oeOn;     // assert output enable
    logic finish;   // capture data, release strobes
    logic ceWake;   // assert chip enable while idle (no standby)
  } ctlStrb_t;

  // timing status returned by the datapath
  typedef struct packed {
    logic addrMet;
    logic ceMet;
    logic oeMet;
    logic oeWindow;
    logic floatMet;
    logic ceIdle;
    logic oeIdle;
  } dpStat_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_FLOAT} rdState_t;

  function automatic int accessNs(input int grade);
    case (grade)
      0:       return 85;
      1:       return 100;
      2:       return 120;
      default: return 150;
    endcase
  endfunction

  function automatic int oeNs(input int grade);
    return (grade >= 3) ? 50 : 40;
  endfunction

  function automatic int floatNs(input int grade);
    case (grade)
      0, 1:    return 30;
      2:       return 35;
      default: return 40;
    endcase
  endfunction

  function automatic int toCycles(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

endpackage

// File: rtl/eprom_rd_satcnt.sv
`timescale 1ns/1ps
module eprom_rd_satcnt #(
  parameter int W   = 5,
  parameter int MAX = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic         run,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = W'(MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (load)
      cnt <= W'(1);
    else if (run && (cnt != TOP))
      cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter bit STANDBY_EN = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  dpStat_t  stat,
  output logic     reqReady,
  output ctlStrb_t strb
);
  rdState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        strb.ceWake = !STANDBY_EN && stat.ceIdle;
        if (reqValid) begin
          strb.launch = 1'b1;
          stateNxt    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        strb.oeOn = stat.oeIdle && stat.oeWindow;
        if (stat.addrMet && stat.ceMet && stat.oeMet) begin
          strb.finish = 1'b1;
          stateNxt    = ST_FLOAT;
        end
      end
      ST_FLOAT: begin
        if (stat.floatMet) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
endmodule

// File: rtl/eprom_rd_dp.sv
`timescale 1ns/1ps
module eprom_rd_dp
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter bit STANDBY_EN = 1'b1,
  parameter int ACC_CYC    = 25,
  parameter int CE_CYC     = 25,
  parameter int OE_CYC     = 10,
  parameter int DF_CYC     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] memData,
  input  ctlStrb_t          strb,
  output dpStat_t           stat,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  localparam int BIG   = (ACC_CYC > CE_CYC) ? ACC_CYC : CE_CYC;
  localparam int BIG2  = (BIG > DF_CYC) ? BIG : DF_CYC;
  localparam int LIM   = ((BIG2 > OE_CYC) ? BIG2 : OE_CYC) + 1;
  localparam int CNT_W = $clog2(LIM + 1);
  localparam int NCNT  = 4;   // 0 address, 1 chip enable, 2 output enable, 3 float
  localparam int OE_LEAD_A = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;
  localparam int OE_LEAD_C = (CE_CYC > OE_CYC) ? CE_CYC - OE_CYC : 0;

  localparam logic [CNT_W-1:0] ACC_C   = CNT_W'(ACC_CYC);
  localparam logic [CNT_W-1:0] CE_C    = CNT_W'(CE_CYC);
  localparam logic [CNT_W-1:0] OE_C    = CNT_W'(OE_CYC);
  localparam logic [CNT_W-1:0] DF_C    = CNT_W'(DF_CYC);
  localparam logic [CNT_W-1:0] LEAD_AC = CNT_W'(OE_LEAD_A);
  localparam logic [CNT_W-1:0] LEAD_CC = CNT_W'(OE_LEAD_C);

  logic [NCNT-1:0]  cntLoad, cntRun;
  logic [CNT_W-1:0] cnt [NCNT];
  logic             ceGoLow, ceGoHigh;

  // chip-enable policy depends on standby option
  generate
    if (STANDBY_EN) begin : gStandby
      assign ceGoLow  = strb.launch;
      assign ceGoHigh = strb.finish;
    end else begin : gAlwaysOn
      assign ceGoLow  = strb.ceWake;
      assign ceGoHigh = 1'b0;
    end
  endgenerate

  always_comb begin
    cntLoad[0] = strb.launch;  cntRun[0] = 1'b1;
    cntLoad[1] = ceGoLow;      cntRun[1] = !memCeN;
    cntLoad[2] = strb.oeOn;    cntRun[2] = !memOeN;
    cntLoad[3] = strb.finish;  cntRun[3] = 1'b1;
  end

  generate
    for (genvar i = 0; i < NCNT; i++) begin : gCnt
      eprom_rd_satcnt #(.W(CNT_W), .MAX(LIM)) uCnt (
        .clk  (clk),
        .rstN (rstN),
        .load (cntLoad[i]),
        .run  (cntRun[i]),
        .cnt  (cnt[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memCeN   <= 1'b1;
      memOeN   <= 1'b1;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.finish;
      if (strb.launch) memAddr <= reqAddr;
      if (ceGoLow)       memCeN <= 1'b0;
      else if (ceGoHigh) memCeN <= 1'b1;
      if (strb.oeOn)        memOeN <= 1'b0;
      else if (strb.finish) memOeN <= 1'b1;
      if (strb.finish) rspData <= memData;
    end
  end

  always_comb begin
    stat.addrMet  = cnt[0] >= ACC_C;
    stat.ceMet    = !memCeN && (cnt[1] >= CE_C);
    stat.oeMet    = !memOeN && (cnt[2] >= OE_C);
    stat.oeWindow = !memCeN && (cnt[0] >= LEAD_AC) && (cnt[1] >= LEAD_CC);
    stat.floatMet = cnt[3] >= DF_C;
    stat.ceIdle   = memCeN;
    stat.oeIdle   = memOeN;
  end
endmodule

// File: rtl/eprom_rd.sv
`timescale 1ns/1ps
module eprom_rd
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int GRADE      = 1,
  parameter int CLK_NS     = 4,
  parameter bit STANDBY_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  input  logic [DATA_W-1:0] memData
);
  localparam int ACC_CYC = toCycles(accessNs(GRADE), CLK_NS);
  localparam int CE_CYC  = ACC_CYC;
  localparam int OE_CYC  = toCycles(oeNs(GRADE), CLK_NS);
  localparam int DF_CYC  = toCycles(floatNs(GRADE), CLK_NS);

  ctlStrb_t strb;
  dpStat_t  stat;

  eprom_rd_ctrl #(.STANDBY_EN(STANDBY_EN)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .stat     (stat),
    .reqReady (reqReady),
    .strb     (strb)
  );

  eprom_rd_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STANDBY_EN(STANDBY_EN),
    .ACC_CYC(ACC_CYC), .CE_CYC(CE_CYC), .OE_CYC(OE_CYC), .DF_CYC(DF_CYC)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (reqAddr),
    .memData  (memData),
    .strb     (strb),
    .stat     (stat),
    .memAddr  (memAddr),
    .memCeN   (memCeN),
    .memOeN   (memOeN),
    .rspValid (rspValid),
    .rspData  (rspData)
  );
endmodule

// File: rtl/eprom_rd_chk.sv
`timescale 1ns/1ps
module eprom_rd_chk #(
  parameter int ADDR_W = 18,
  parameter int DF_CYC = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN
);
  localparam int GW = $clog2(DF_CYC + 1) + 1;
  localparam logic [GW-1:0] GAP_MIN = GW'(DF_CYC);
  logic [GW-1:0] gap;

  // cycles since output enable was last released
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           gap <= GAP_MIN;
    else if (!memOeN)    gap <= '0;
    else if (gap < GAP_MIN) gap <= gap + GW'(1);
  end

  assert_oe_under_ce_R10: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memCeN);

  assert_launch_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (memAddr == $past(reqAddr)));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |=> $stable(memAddr));

  assert_rsp_after_oe_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !$past(memOeN));

  assert_oe_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> memOeN);

  assert_float_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (gap >= GAP_MIN));

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

bind eprom_rd eprom_rd_chk #(.ADDR_W(ADDR_W), .DF_CYC(DF_CYC)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .memAddr  (memAddr),
  .memCeN   (memCeN),
  .memOeN   (memOeN)
);

// File: tb/sim_eprom_rd.sv
`timescale 1ns/1ps
// behavioural memory: junk until every access limit has elapsed
module sim_rom #(
  parameter int ACC = 25,
  parameter int OEC = 10
) (
  input  logic        clk,
  input  logic [17:0] addr,
  input  logic        ceN,
  input  logic        oeN,
  output logic [15:0] data
);
  int aEl = 0, cEl = 0, oEl = 0;
  logic [17:0] lastA = '0;
  logic lastCe = 1'b1, lastOe = 1'b1;

  function automatic logic [15:0] word(input logic [17:0] a);
    return {a[1:0], a[17:4]} ^ 16'h5A3C;
  endfunction

  always @(negedge clk) begin
    if (addr !== lastA) aEl = 1; else if (aEl < 1000) aEl++;
    if (ceN) cEl = 0; else if (lastCe) cEl = 1; else if (cEl < 1000) cEl++;
    if (oeN) oEl = 0; else if (lastOe) oEl = 1; else if (oEl < 1000) oEl++;
    lastA = addr; lastCe = ceN; lastOe = oeN;
  end

  assign data = (!ceN && !oeN && aEl >= ACC && cEl >= ACC && oEl >= OEC) ? word(addr) : 16'hDEAD;
endmodule

module sim_eprom_rd;
  // R8: grade 1 at 4 ns -> ceil(100/4)=25, ceil(40/4)=10, ceil(30/4)=8
  localparam int ACC = 25;
  localparam int OEC = 10;
  localparam int DFC = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, reqValid = 1'b0;
  logic [17:0] reqAddr = '0;

  logic r0Ready, r0Rsp, r0CeN, r0OeN, r1Ready, r1Rsp, r1CeN, r1OeN;
  logic [15:0] r0Data, r1Data, m0Data, m1Data;
  logic [17:0] r0Addr, r1Addr;

  int total = 0, bad = 0, nReq = 0, nRsp = 0;

  eprom_rd #(.GRADE(1), .CLK_NS(4), .STANDBY_EN(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(r0Ready), .rspValid(r0Rsp), .rspData(r0Data),
    .memAddr(r0Addr), .memCeN(r0CeN), .memOeN(r0OeN), .memData(m0Data));

  eprom_rd #(.GRADE(1), .CLK_NS(4), .STANDBY_EN(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(r1Ready), .rspValid(r1Rsp), .rspData(r1Data),
    .memAddr(r1Addr), .memCeN(r1CeN), .memOeN(r1OeN), .memData(m1Data));

  sim_rom #(.ACC(ACC), .OEC(OEC)) uRom0 (.clk(clk), .addr(r0Addr), .ceN(r0CeN), .oeN(r0OeN), .data(m0Data));
  sim_rom #(.ACC(ACC), .OEC(OEC)) uRom1 (.clk(clk), .addr(r1Addr), .ceN(r1CeN), .oeN(r1OeN), .data(m1Data));

  function automatic logic [15:0] word(input logic [17:0] a);
    return {a[1:0], a[17:4]} ^ 16'h5A3C;
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, evaluated at each rising edge
  int phase = 0, t = 0, accCount = 0;
  logic [17:0] expAddr = '0;
  logic [15:0] expData = '0;
  logic expReady = 1'b1, expOeN = 1'b1, expCe0N = 1'b1, expCe1N = 1'b1, expRsp = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      phase = 0; expReady = 1; expOeN = 1; expCe0N = 1; expCe1N = 1;
      expRsp = 0; expAddr = '0; expData = '0;
    end else begin
      expRsp = 0;
      expCe1N = 0;
      case (phase)
        0: if (reqValid) begin
             phase = 1; t = 0; expAddr = reqAddr; expCe0N = 0; expReady = 0; accCount++;
           end
        1: begin
             t++;
             if (t == ACC - OEC) expOeN = 0;
             if (t == ACC) begin
               expRsp = 1; expData = word(expAddr); expOeN = 1; expCe0N = 1; phase = 2; t = 0;
             end
           end
        default: begin
             t++;
             if (t == DFC) begin phase = 0; expReady = 1; end
           end
      endcase
    end
  end

  // per-cycle comparison and latency probes
  int lat = -1, gp = -1;
  logic prevCe = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      cmp("R6 u0 reqReady", 32'(r0Ready), 32'(expReady));
      cmp("R4 u0 rspValid", 32'(r0Rsp), 32'(expRsp));
      cmp("R4 R9 u0 rspData", 32'(r0Data), 32'(expData));
      cmp("R2 u0 memAddr", 32'(r0Addr), 32'(expAddr));
      cmp("R3 R5 u0 memOeN", 32'(r0OeN), 32'(expOeN));
      cmp("R2 R5 u0 memCeN", 32'(r0CeN), 32'(expCe0N));
      cmp("R6 u1 reqReady", 32'(r1Ready), 32'(expReady));
      cmp("R4 u1 rspValid", 32'(r1Rsp), 32'(expRsp));
      cmp("R4 u1 rspData", 32'(r1Data), 32'(expData));
      cmp("R3 u1 memOeN", 32'(r1OeN), 32'(expOeN));
      cmp("R7 u1 memCeN", 32'(r1CeN), 32'(expCe1N));
      cmp("R10 u0 oe under ce", 32'(!r0OeN && r0CeN), 32'(0));
      cmp("R10 u1 oe under ce", 32'(!r1OeN && r1CeN), 32'(0));
      if (r0Rsp) nRsp++;
      // R8 latency measured from chip-enable fall in standby
      if (lat >= 0) lat++;
      if (prevCe && !r0CeN) lat = 0;
      if (lat == ACC - OEC && !r0OeN) cmp("R8 R3 oe lead", 32'(lat), 32'(ACC - OEC));
      if (r0Rsp && lat >= 0) begin cmp("R8 access cycles", 32'(lat), 32'(ACC)); lat = -1; end
      if (gp >= 0) gp++;
      if (r0Rsp) gp = 0;
      if (gp > 0 && r0Ready) begin cmp("R8 R6 float cycles", 32'(gp), 32'(DFC)); gp = -1; end
      prevCe = r0CeN;
    end
  end

  task automatic doReq(input logic [17:0] a);
    int n;
    n = accCount;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    wait (accCount != n);
    @(negedge clk);
    reqValid = 1'b0;
    nReq++;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: quiet state under reset
    cmp("R1 reqReady", 32'(r0Ready), 32'(1));
    cmp("R1 memCeN", 32'(r0CeN), 32'(1));
    cmp("R1 memOeN", 32'(r0OeN), 32'(1));
    cmp("R1 rspValid", 32'(r0Rsp), 32'(0));
    cmp("R1 u1 memCeN", 32'(r1CeN), 32'(1));
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    doReq(18'h12345);
    repeat (40) @(negedge clk);
    doReq(18'h3FFFF);
    // back-to-back: next request waits through access and float (R6)
    doReq(18'h00001);
    doReq(18'h2A5A5);
    // stray request during access, withdrawn before ready: ignored (R6)
    repeat (5) @(negedge clk);
    reqValid = 1'b1; reqAddr = 18'h15555;
    repeat (4) @(negedge clk);
    reqValid = 1'b0;
    repeat (40) @(negedge clk);
    doReq(18'h00000);
    doReq(18'h1F0F0);
    repeat (50) @(negedge clk);
    cmp("R6 response count", 32'(nRsp), 32'(nReq));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule